// File: doc/BRIEF.md
# Message-Signaled Interrupt Generator

This block sits on the device side of a system and reports interrupt events as memory writes, not as levels on dedicated wires. Each interrupt vector has one entry in a small table held in registers. An entry holds a target address, a data word and a mask bit. When an event arrives on a vector that is enabled, the block issues one write of that entry's data word to that entry's address. The write goes out on an outbound port that uses a valid/ready handshake.

Events follow edge semantics. Every event leads to exactly one write, and nothing needs to be acknowledged or deasserted afterwards. An event on a masked vector is not lost. It is held as a pending bit, and one message is sent once the vector is unmasked. A global enable can hold back all traffic in the same way. Repeated events that arrive before a vector's message leaves the table merge into that single message. When several vectors are ready at once, they take turns on the port in ascending vector order.

Software sets up the table through a simple register port. The same port reads back the pending bits.

Top module: `msi_gen`

## Requirements
- R1: After reset every vector is masked, the global enable is clear, no vector is pending and `wr_valid` is low.
- R2: Register decode: when `cfg_addr[VEC_W+2]` is 1 it selects the control register, whose bit 0 is the global enable. Otherwise `cfg_addr` is {vector, field}, where `cfg_addr[1:0]` picks the field: 0 is the target address, 1 is the data word, 2 is the mask (bit 0, 1 = masked) and 3 is pending (bit 0, read-only). Writes take effect on a clock edge where `cfg_wr` is 1. Reads are combinational on `cfg_rdata`.
- R3: Suppose an event is sampled on an unmasked vector at edge E, the global enable is set and the port is idle. Then `wr_valid` is high after edge E+1, carrying that entry's address and data. Exactly one write results, and no write ever appears without a cause.
- R4: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged.
- R5: An event on a masked vector sets its pending bit and produces no write. Clearing the mask sends exactly one message and clears the pending bit.
- R6: Masking one vector has no effect on the delivery of any other vector.
- R7: Vectors that are ready at the same time are sent one at a time in ascending vector order. Each message waits for its own handshake.
- R8: While the global enable is clear, no write starts and events are held as pending. Setting the enable sends them.
- R9: Any number of events on a vector before its message is launched merge into one message. An event after launch queues a further message.
- R10: The pending bit of every vector can be read through the register port.
- R11: The address and data are taken from the table at the moment a message is launched. A later table write does not change a message that is already in flight, but it does apply to later messages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_VEC | One-cycle event strobes, one per vector |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | VEC_W+3 | Register address |
| cfg_wdata | input | CFG_W | Register write data |
| cfg_rdata | output | CFG_W | Register read data (combinational) |
| wr_valid | output | 1 | Outbound write request |
| wr_ready | input | 1 | Outbound write accepted |
| wr_addr | output | ADDR_W | Outbound write target address |
| wr_data | output | DATA_W | Outbound write data |

## Verification
A pending bit that is wrongly lost shows up as a missing write, which the scoreboard notices when the bench drains its queue. A pending bit that is wrongly kept shows up as an extra write or a wrong readback one cycle after the mask or enable changes. If the selection order or the capture at launch is wrong, the scoreboard finds a mismatched address or data word on the very handshake involved. A broken hold under back-pressure shows as a value that changes across a stall lasting a few cycles.

// File: rtl/msi_gen.sv
module msi_gen #(
  parameter int NUM_VEC = 8,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  localparam int VEC_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int CFG_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W,
  localparam int CA_W   = VEC_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] evt_i,
  input  logic               cfg_wr,
  input  logic [CA_W-1:0]    cfg_addr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [CFG_W-1:0]   cfg_rdata,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0]  wr_data
);

  logic [ADDR_W-1:0]  tbl_addr [NUM_VEC];
  logic [DATA_W-1:0]  tbl_data [NUM_VEC];
  logic [NUM_VEC-1:0] mask, pend;
  logic               glb_en;
  logic [VEC_W-1:0]   sel;
  logic               found;

  wire [NUM_VEC-1:0] cand    = pend & ~mask;
  wire               launch  = glb_en && found && (!wr_valid || wr_ready);
  wire [NUM_VEC-1:0] clr     = launch ? (NUM_VEC'(1) << sel) : '0;
  wire               is_ctrl = cfg_addr[CA_W-1];
  wire [VEC_W-1:0]   cfg_vec = cfg_addr[VEC_W+1:2];
  wire [1:0]         cfg_fld = cfg_addr[1:0];
  wire               vec_ok  = int'(cfg_vec) < NUM_VEC;
  wire               ent_wr  = cfg_wr && !is_ctrl && vec_ok;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--)
      if (cand[i]) begin
        found = 1'b1;
        sel   = VEC_W'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_en <= 1'b0;
      mask   <= '1;
      pend   <= '0;
      for (int i = 0; i < NUM_VEC; i++) begin
        tbl_addr[i] <= '0;
        tbl_data[i] <= '0;
      end
    end else begin
      pend <= (pend & ~clr) | evt_i;
      if (cfg_wr && is_ctrl) glb_en <= cfg_wdata[0];
      if (ent_wr) begin
        case (cfg_fld)
          2'd0:    tbl_addr[cfg_vec] <= cfg_wdata[ADDR_W-1:0];
          2'd1:    tbl_data[cfg_vec] <= cfg_wdata[DATA_W-1:0];
          2'd2:    mask[cfg_vec]     <= cfg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (launch) begin
      wr_valid <= 1'b1;
      wr_addr  <= tbl_addr[sel];
      wr_data  <= tbl_data[sel];
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (is_ctrl) cfg_rdata[0] = glb_en;
    else if (vec_ok) begin
      case (cfg_fld)
        2'd0:    cfg_rdata = CFG_W'(tbl_addr[cfg_vec]);
        2'd1:    cfg_rdata = CFG_W'(tbl_data[cfg_vec]);
        2'd2:    cfg_rdata[0] = mask[cfg_vec];
        default: cfg_rdata[0] = pend[cfg_vec];
      endcase
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R4

  AST_GLB_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(glb_en)); // R8

  AST_MASK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend) & $past(mask)) & ~pend) == '0)); // R5

  AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (!pend[$past(sel)] || $past(evt_i[sel]))); // R9

endmodule

// File: tb/tb_msi_gen.sv
module tb_msi_gen;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  evt = 0;
  logic        cfg_wr = 0;
  logic [5:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic        wr_valid, wr_ready = 0;
  logic [31:0] wr_addr, wr_data;

  msi_gen dut (.clk(clk), .rst_n(rst_n), .evt_i(evt), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
               .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wr_valid(wr_valid),
               .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, sent = 0, rdy_mode = 0, rcnt = 0;
  bit done = 0;
  logic [63:0] expq[$];
  string       tagq[$];
  logic [31:0] m_addr [8];
  logic [31:0] m_data [8];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    rcnt++;
    case (rdy_mode)
      0: wr_ready = 1;
      1: wr_ready = 0;
      default: wr_ready = (rcnt % 3) != 0;
    endcase
  end

  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      sent++;
      if (expq.size() == 0) chk(0, "R3 unexpected write", {wr_addr, wr_data}, 64'h0);
      else begin
        logic [63:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk({wr_addr, wr_data} == e, t, {wr_addr, wr_data}, e);
      end
    end
  end

  function automatic logic [5:0] ent(input int v, input int f);
    return {1'b0, 3'(v), 2'(f)};
  endfunction

  task automatic expect_msg(input int v, input string tag);
    expq.push_back({m_addr[v], m_data[v]});
    tagq.push_back(tag);
  endtask

  task automatic cwr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 0;
  endtask

  task automatic crd(input logic [5:0] a, output logic [31:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(posedge clk); #1; evt = m;
    @(posedge clk); #1; evt = 0;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while ((expq.size() != 0 || wr_valid) && n < 300) begin
      @(posedge clk); n++;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(expq.size() == 0, tag, 64'(expq.size()), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, a0;
    int base;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk(wr_valid == 0, "R1 wr_valid after reset", 64'(wr_valid), 64'h0);
    crd(6'b100000, rd); chk(rd[0] == 0, "R1 global enable clear", 64'(rd), 64'h0);
    for (int v = 0; v < 8; v++) begin
      crd(ent(v, 2), rd); chk(rd[0] == 1, "R1 mask set", 64'(rd), 64'h1);
      crd(ent(v, 3), rd); chk(rd[0] == 0, "R1 not pending", 64'(rd), 64'h0);
    end

    for (int v = 0; v < 8; v++) begin
      m_addr[v] = 32'h4000_0000 + 32'(v * 16);
      m_data[v] = 32'h0000_0100 + 32'(v * 3);
      cwr(ent(v, 0), m_addr[v]);
      cwr(ent(v, 1), m_data[v]);
      cwr(ent(v, 2), 32'h0);
    end
    crd(ent(5, 0), rd); chk(rd == m_addr[5], "R2 address readback", 64'(rd), 64'(m_addr[5]));
    crd(ent(5, 1), rd); chk(rd == m_data[5], "R2 data readback", 64'(rd), 64'(m_data[5]));
    crd(ent(5, 2), rd); chk(rd[0] == 0, "R2 mask readback", 64'(rd), 64'h0);
    cwr(6'b100000, 32'h1);
    crd(6'b100000, rd); chk(rd[0] == 1, "R2 enable readback", 64'(rd), 64'h1);

    rdy_mode = 0;
    expect_msg(3, "R3 single message");
    pulse(8'h08);
    @(posedge clk); #1;
    chk(wr_valid == 1, "R3 latency", 64'(wr_valid), 64'h1);
    drain("R3 drained");

    rdy_mode = 2;
    expect_msg(1, "R7 order first"); expect_msg(5, "R7 order second"); expect_msg(6, "R7 order third");
    pulse(8'b0110_0010);
    drain("R7 drained");

    rdy_mode = 1;
    expect_msg(4, "R7 in flight"); expect_msg(2, "R7 lower next"); expect_msg(7, "R7 higher last");
    pulse(8'h10);
    pulse(8'h84);
    a0 = wr_addr;
    repeat (3) @(posedge clk);
    #1;
    chk(wr_valid == 1 && wr_addr == a0, "R4 held under stall", {31'h0, wr_valid, wr_addr}, {31'h0, 1'b1, a0});
    rdy_mode = 0;
    drain("R7 stall drained");

    rdy_mode = 1;
    base = sent;
    expect_msg(6, "R9 launched"); expect_msg(6, "R9 merged");
    pulse(8'h40);
    repeat (2) @(posedge clk);
    pulse(8'h40);
    pulse(8'h40);
    pulse(8'h40);
    crd(ent(6, 3), rd); chk(rd[0] == 1, "R10 pending visible", 64'(rd), 64'h1);
    rdy_mode = 0;
    drain("R9 drained");
    chk(sent - base == 2, "R9 merge count", 64'(sent - base), 64'h2);

    base = sent;
    cwr(ent(4, 2), 32'h1);
    pulse(8'h10); pulse(8'h10); pulse(8'h10);
    repeat (5) @(posedge clk);
    #1;
    chk(wr_valid == 0 && sent == base, "R5 masked no write", 64'(sent - base), 64'h0);
    crd(ent(4, 3), rd); chk(rd[0] == 1, "R5 pending set", 64'(rd), 64'h1);
    expect_msg(4, "R5 replay");
    cwr(ent(4, 2), 32'h0);
    drain("R5 drained");
    chk(sent - base == 1, "R5 one replay", 64'(sent - base), 64'h1);
    crd(ent(4, 3), rd); chk(rd[0] == 0, "R5 pending cleared", 64'(rd), 64'h0);

    cwr(ent(0, 2), 32'h1);
    expect_msg(7, "R6 other vector delivered");
    pulse(8'h81);
    drain("R6 drained");
    crd(ent(0, 3), rd); chk(rd[0] == 1, "R6 masked kept pending", 64'(rd), 64'h1);
    crd(ent(7, 3), rd); chk(rd[0] == 0, "R6 other not pending", 64'(rd), 64'h0);
    expect_msg(0, "R6 unmask replay");
    cwr(ent(0, 2), 32'h0);
    drain("R6 replay drained");

    base = sent;
    cwr(6'b100000, 32'h0);
    pulse(8'h0A);
    repeat (6) @(posedge clk);
    #1;
    chk(wr_valid == 0 && sent == base, "R8 disabled no write", 64'(sent - base), 64'h0);
    crd(ent(1, 3), rd); chk(rd[0] == 1, "R8 v1 pending", 64'(rd), 64'h1);
    crd(ent(3, 3), rd); chk(rd[0] == 1, "R8 v3 pending", 64'(rd), 64'h1);
    expect_msg(1, "R8 release first"); expect_msg(3, "R8 release second");
    cwr(6'b100000, 32'h1);
    drain("R8 drained");

    m_data[3] = 32'hDEAD_0003;
    cwr(ent(3, 1), m_data[3]);
    expect_msg(3, "R11 new table data");
    pulse(8'h08);
    drain("R11 drained");

    rdy_mode = 1;
    expect_msg(2, "R11 captured at launch");
    pulse(8'h04);
    @(posedge clk);
    m_data[2] = 32'hBEEF_0002;
    cwr(ent(2, 1), m_data[2]);
    rdy_mode = 0;
    drain("R11 in-flight drained");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule